// File: doc/BRIEF.md
# ADC Power and Gain Sequencer

This block sits between a host and an external parallel sampling converter. It drives the converter's two active-low power-down controls (a deep sleep and a light nap) and its two-bit input span select. The host asks for a new combination of power mode and span through a request/acknowledge handshake. The block applies the new pin values at once and then holds `ready_o` low for as long as the converter needs to wake up or to let its span reference settle.

A conversion controller gates its conversion starts on `ready_o`. The wait that follows each request depends on the transition. Leaving sleep is the slowest wake-up and leaving nap is brief. Moving to either of the two lowest spans takes the longest settling. Between the two highest spans the wait is asymmetric: charging up is fast and discharging down is slow, unless a faster-discharge build option is selected. Every wait is a parameter counted in system clock cycles. The analog settling itself is not modelled; the block only times it.

Top module: `adc_pwr_gain_seq`

## Requirements
- R1: After reset, `sleep_n_o` and `nap_n_o` are 1, `gain_o` is 2'b11 (0 dB), `ack_o` is 0 and `ready_o` is 1.
- R2: A request is taken on a rising clock edge where `req_i` is 1 and `ack_o` is 0. `ack_o` is then 1 for exactly that one following cycle.
- R3: On the edge that takes a request, `sleep_n_o` becomes the inverse of `req_sleep_i`, `nap_n_o` becomes the inverse of `req_nap_i`, and `gain_o` becomes `req_gain_i`. In `gain_o`, bit 0 selects the first gain pin and bit 1 the second. The codes are 2'b11 = 0 dB, 2'b01 = -3 dB, 2'b10 = -6 dB and 2'b00 = -9 dB.
- R4: `ready_o` is 0 whenever `sleep_n_o` or `nap_n_o` is 0.
- R5: A request that releases sleep holds `ready_o` low for T_SLEEP_WAKE cycles after the accepting edge. This also applies when nap was low at the same time, because sleep has priority.
- R6: A request that releases nap while sleep was not low holds `ready_o` low for T_NAP_WAKE cycles.
- R7: A span change to 0 dB or -3 dB that is not 0 dB to -3 dB holds `ready_o` low for T_GAIN_UP cycles. This covers -3 dB to 0 dB, and any move from -6 dB or -9 dB.
- R8: A change from 0 dB to -3 dB holds `ready_o` low for T_GAIN_DN_SLOW cycles, or for T_GAIN_DN_FAST cycles when FAST_DISCHARGE is 1.
- R9: A change to -6 dB or -9 dB from any other span holds `ready_o` low for T_GAIN_LOW cycles.
- R10: When a request both wakes the converter and changes the span, the wait is the larger of the two individual waits.
- R11: A request that repeats the current settings causes no wait: `ready_o` stays 1.
- R12: A request taken while a wait is still running restarts the wait from the new transition, counted from the new accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request strobe, held until acknowledged |
| req_sleep_i | input | 1 | Requested deep sleep (1 = sleep) |
| req_nap_i | input | 1 | Requested nap (1 = nap) |
| req_gain_i | input | 2 | Requested span code |
| ack_o | output | 1 | One-cycle acknowledge of a taken request |
| sleep_n_o | output | 1 | Active-low sleep control to the converter |
| nap_n_o | output | 1 | Active-low nap control to the converter |
| gain_o | output | 2 | Span select to the converter |
| ready_o | output | 1 | Conversion starts permitted |

## Verification
The bench builds two copies with small wait values: sleep 40, nap 3, span up 7, slow discharge 20, fast discharge 9 and low spans 30 cycles. One copy uses the slow-discharge variant and the other the fast one. These short waits allow every one of the sixteen span-to-span moves and every one of the sixteen power-mode moves to be timed to the exact cycle, including the combined wake-plus-span cases. The mid-wait restart is also checked, with both discharge variants compared side by side on the same stimulus.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Span codes: bit 0 drives the first gain pin, bit 1 the second.
   localparam logic [1:0] SPAN_0DB  = 2'b11;
   localparam logic [1:0] SPAN_M3DB = 2'b01;
   localparam logic [1:0] SPAN_M6DB = 2'b10;
   localparam logic [1:0] SPAN_M9DB = 2'b00;

   typedef struct packed {
      logic       sleep;
      logic       nap;
      logic [1:0] span;
   } seq_cfg_t;

   localparam seq_cfg_t CFG_RESET = '{sleep: 1'b0, nap: 1'b0, span: SPAN_0DB};

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_delay_sel.sv
module adc_seq_delay_sel
   import adc_seq_pkg::*;
#(
   parameter int unsigned CNT_W          = 8,
   parameter int unsigned T_SLEEP_WAKE   = 40,
   parameter int unsigned T_NAP_WAKE     = 3,
   parameter int unsigned T_GAIN_UP      = 7,
   parameter int unsigned T_GAIN_DN_SLOW = 20,
   parameter int unsigned T_GAIN_DN_FAST = 9,
   parameter int unsigned T_GAIN_LOW     = 30,
   parameter bit          FAST_DISCHARGE = 1'b0
) (
   input  seq_cfg_t         cur_i,
   input  seq_cfg_t         nxt_i,
   output logic [CNT_W-1:0] wait_o
);

   logic [CNT_W-1:0] t_down;
   logic [CNT_W-1:0] wake_w;
   logic [CNT_W-1:0] span_w;

   generate
      if (FAST_DISCHARGE) begin : g_fast_dn
         assign t_down = CNT_W'(T_GAIN_DN_FAST);
      end else begin : g_slow_dn
         assign t_down = CNT_W'(T_GAIN_DN_SLOW);
      end
   endgenerate

   always_comb begin
      wake_w = '0;
      if (cur_i.sleep && !nxt_i.sleep)
         wake_w = CNT_W'(T_SLEEP_WAKE);
      else if (cur_i.nap && !nxt_i.nap)
         wake_w = CNT_W'(T_NAP_WAKE);
   end

   always_comb begin
      span_w = '0;
      if (nxt_i.span != cur_i.span) begin
         if (!nxt_i.span[0])
            span_w = CNT_W'(T_GAIN_LOW);       // -6 dB or -9 dB
         else if (cur_i.span == SPAN_0DB)
            span_w = t_down;                   // only -3 dB remains
         else
            span_w = CNT_W'(T_GAIN_UP);
      end
   end

   assign wait_o = (wake_w > span_w) ? wake_w : span_w;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (load_i)
         count_q <= load_val_i;
      else if (count_q != '0)
         count_q <= count_q - CNT_W'(1);
   end

   assign zero_o = (count_q == '0);

   assert_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_q == $past(load_val_i));

   assert_count_down_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));

endmodule

// File: rtl/adc_pwr_gain_seq.sv
module adc_pwr_gain_seq
   import adc_seq_pkg::*;
#(
   parameter int unsigned T_SLEEP_WAKE   = 1_000_000,
   parameter int unsigned T_NAP_WAKE     = 20,
   parameter int unsigned T_GAIN_UP      = 300_000,
   parameter int unsigned T_GAIN_DN_SLOW = 40_000_000,
   parameter int unsigned T_GAIN_DN_FAST = 10_000_000,
   parameter int unsigned T_GAIN_LOW     = 60_000_000,
   parameter bit          FAST_DISCHARGE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       req_sleep_i,
   input  logic       req_nap_i,
   input  logic [1:0] req_gain_i,
   output logic       ack_o,
   output logic       sleep_n_o,
   output logic       nap_n_o,
   output logic [1:0] gain_o,
   output logic       ready_o
);

   localparam int unsigned MAX_WAIT = umax(umax(T_SLEEP_WAKE, T_NAP_WAKE),
                                      umax(umax(T_GAIN_UP, T_GAIN_LOW),
                                           umax(T_GAIN_DN_SLOW, T_GAIN_DN_FAST)));
   localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

   generate
      if (T_SLEEP_WAKE == 0 || T_NAP_WAKE == 0) begin : g_bad_wake
         $error("wake-up waits must be at least one cycle");
      end
      if (T_GAIN_DN_FAST > T_GAIN_DN_SLOW) begin : g_bad_discharge
         $error("fast discharge wait exceeds slow discharge wait");
      end
   endgenerate

   seq_cfg_t         cfg_q;
   seq_cfg_t         cfg_nxt;
   logic             ack_q;
   logic             take;
   logic             settled;
   logic [CNT_W-1:0] wait_val;

   assign take    = req_i && !ack_q;
   assign cfg_nxt = '{sleep: req_sleep_i, nap: req_nap_i, span: req_gain_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         ack_q <= 1'b0;
      end else begin
         ack_q <= take;
         if (take)
            cfg_q <= cfg_nxt;
      end
   end

   adc_seq_delay_sel #(
      .CNT_W          (CNT_W),
      .T_SLEEP_WAKE   (T_SLEEP_WAKE),
      .T_NAP_WAKE     (T_NAP_WAKE),
      .T_GAIN_UP      (T_GAIN_UP),
      .T_GAIN_DN_SLOW (T_GAIN_DN_SLOW),
      .T_GAIN_DN_FAST (T_GAIN_DN_FAST),
      .T_GAIN_LOW     (T_GAIN_LOW),
      .FAST_DISCHARGE (FAST_DISCHARGE)
   ) u_sel (
      .cur_i  (cfg_q),
      .nxt_i  (cfg_nxt),
      .wait_o (wait_val)
   );

   adc_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (take),
      .load_val_i (wait_val),
      .zero_o     (settled)
   );

   assign ack_o     = ack_q;
   assign sleep_n_o = !cfg_q.sleep;
   assign nap_n_o   = !cfg_q.nap;
   assign gain_o    = cfg_q.span;
   assign ready_o   = settled && !cfg_q.sleep && !cfg_q.nap;

   assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   assert_pins_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (sleep_n_o == !$past(req_sleep_i)) && (nap_n_o == !$past(req_nap_i))
               && (gain_o == $past(req_gain_i)));

   assert_pins_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(gain_o) && $stable(sleep_n_o) && $stable(nap_n_o));

   assert_sleep_exit_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !sleep_n_o && !req_sleep_i) |=> !ready_o);

   assert_same_cfg_no_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ready_o && cfg_nxt == cfg_q) |=> ready_o);

endmodule

// File: tb/sim_adc_pwr_gain_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_gain_seq;

   localparam int TS = 40, TN = 3, TU = 7, TDS = 20, TDF = 9, TL = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0, rs = 1'b0, rn = 1'b0;
   logic [1:0] rg = 2'b11;
   logic       ack0, sn0, nn0, rdy0;
   logic [1:0] g0;
   logic       ack1, sn1, nn1, rdy1;
   logic [1:0] g1;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   bit cs = 1'b0, cn = 1'b0;
   logic [1:0] cg = 2'b11;

   always #4 clk = ~clk;

   adc_pwr_gain_seq #(.T_SLEEP_WAKE(TS), .T_NAP_WAKE(TN), .T_GAIN_UP(TU),
      .T_GAIN_DN_SLOW(TDS), .T_GAIN_DN_FAST(TDF), .T_GAIN_LOW(TL), .FAST_DISCHARGE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_sleep_i(rs), .req_nap_i(rn), .req_gain_i(rg),
      .ack_o(ack0), .sleep_n_o(sn0), .nap_n_o(nn0), .gain_o(g0), .ready_o(rdy0));

   adc_pwr_gain_seq #(.T_SLEEP_WAKE(TS), .T_NAP_WAKE(TN), .T_GAIN_UP(TU),
      .T_GAIN_DN_SLOW(TDS), .T_GAIN_DN_FAST(TDF), .T_GAIN_LOW(TL), .FAST_DISCHARGE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_sleep_i(rs), .req_nap_i(rn), .req_gain_i(rg),
      .ack_o(ack1), .sleep_n_o(sn1), .nap_n_o(nn1), .gain_o(g1), .ready_o(rdy1));

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_wait(input bit ns, input bit nn, input logic [1:0] ng, input bit fast);
      int w = 0;
      int g = 0;
      if (cs && !ns) w = TS;
      else if (cn && !nn) w = TN;
      if (ng != cg) begin
         if (ng == 2'b10 || ng == 2'b00) g = TL;
         else if (cg == 2'b11 && ng == 2'b01) g = fast ? TDF : TDS;
         else g = TU;
      end
      return (w > g) ? w : g;
   endfunction

   task automatic do_req(input bit s, input bit n, input logic [1:0] g,
                         input string tag, input bit measure);
      int e0 = exp_wait(s, n, g, 1'b0);
      int e1 = exp_wait(s, n, g, 1'b1);
      int c0 = 0, c1 = 0, guard = 0;
      @(negedge clk);
      req = 1'b1; rs = s; rn = n; rg = g;
      @(negedge clk);
      check("R2 ack", int'(ack0), 1);
      check("R3 sleep pin", int'(sn0), int'(!s));
      check("R3 nap pin", int'(nn0), int'(!n));
      check("R3 span pins", int'(g0), int'(g));
      req = 1'b0;
      cs = s; cn = n; cg = g;
      if (!measure) return;
      if (s || n) begin
         for (int k = 0; k < 3; k++) begin
            check("R4 ready low in power-down", int'(rdy0), 0);
            @(negedge clk);
         end
         check("R2 ack dropped", int'(ack0), 0);
         return;
      end
      while ((!rdy0 || !rdy1) && guard < 200) begin
         if (!rdy0) c0++;
         if (!rdy1) c1++;
         guard++;
         @(negedge clk);
      end
      check({tag, " wait slow variant"}, c0, e0);
      check({tag, " wait fast variant"}, c1, e1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 sleep_n", int'(sn0), 1);
      check("R1 nap_n", int'(nn0), 1);
      check("R1 gain", int'(g0), 3);
      check("R1 ack", int'(ack0), 0);
      check("R1 ready", int'(rdy0), 1);

      // Span sweep: all 16 old/new pairs (R7, R8, R9, R11)
      for (int o = 0; o < 4; o++) begin
         for (int n = 0; n < 4; n++) begin
            string t;
            do_req(1'b0, 1'b0, 2'(o), "setup", 1'b1);
            if (n == o) t = "R11";
            else if (n == 0 || n == 2) t = "R9";
            else if (o == 3 && n == 1) t = "R8";
            else t = "R7";
            do_req(1'b0, 1'b0, 2'(n), t, 1'b1);
         end
      end

      // Power-mode sweep: all 16 old/new pairs (R4, R5, R6, R11)
      for (int o = 0; o < 4; o++) begin
         for (int n = 0; n < 4; n++) begin
            string t;
            do_req(o[1], o[0], cg, "setup", 1'b1);
            if (o[1] && !n[1]) t = "R5";
            else if (o[0] && !n[0]) t = "R6";
            else t = "R11";
            do_req(n[1], n[0], cg, t, 1'b1);
         end
      end

      // Combined wake and span change (R10)
      do_req(1'b0, 1'b0, 2'b11, "setup", 1'b1);
      do_req(1'b1, 1'b0, 2'b11, "setup", 1'b1);
      do_req(1'b0, 1'b0, 2'b10, "R10 sleep+low", 1'b1);
      do_req(1'b0, 1'b1, 2'b10, "setup", 1'b1);
      do_req(1'b0, 1'b0, 2'b01, "R10 nap+up", 1'b1);
      do_req(1'b0, 1'b1, 2'b11, "setup", 1'b1);
      do_req(1'b0, 1'b0, 2'b01, "R10 nap+down", 1'b1);

      // Restart during a running wait (R12)
      do_req(1'b0, 1'b0, 2'b11, "setup", 1'b1);
      do_req(1'b0, 1'b0, 2'b00, "R12 first", 1'b0);
      repeat (5) @(negedge clk);
      check("R12 ready low mid-wait", int'(rdy0), 0);
      do_req(1'b0, 1'b0, 2'b01, "R12 restart", 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule